// File: doc/BRIEF.md
# Load/Store Address and Memory Sequencer

This block executes the data-movement class of instructions for a 16-bit, word-addressed machine with a 64K-word address space. When `start` is pulsed with an instruction word and the already-incremented program counter, it forms an effective address. That address is either the program counter plus a sign-extended 9-bit offset, or a base register plus a sign-extended 6-bit offset. The block then runs the memory traffic through an internal address register and data register, one memory cycle per access.

Four kinds of operation are handled. Plain loads and stores make one access. Indirect loads and stores first read a pointer word and then use it as the operand address, so they make two accesses. The address-only operation writes the computed address itself into a register and does not touch memory. Every operation that writes a register also updates the sign flags. A one-cycle `done` pulse marks the cycle in which the final register write or memory write happens.

The memory port is synchronous. A read request in one cycle returns its word on `mem_rdata` in the next cycle. A write is taken at the clock edge that ends the request cycle. The register file is outside the block. It offers two combinational read ports, one for the base register and one for store data, and one write port.

Top module: `ldst_seq`

## Requirements
- R1: Opcodes 0010 (load), 0011 (store) and 1110 (address-only) form their address as `pc_next` plus instr[8:0] sign-extended to 16 bits, with 16-bit wraparound.
- R2: Opcodes 0110 (base load) and 0111 (base store) form their address as the register selected by instr[8:6] plus instr[5:0] sign-extended. That register is read through `rf_ra_idx`/`rf_ra_data`.
- R3: Opcode 1110 writes its address into the register named by instr[11:9] and makes no memory request. `done` is high in the 2nd cycle after the edge that accepts `start`.
- R4: Opcodes 0010 and 0110 read one word at the address. That word is written into the register named by instr[11:9], with `done` in the 4th cycle after acceptance.
- R5: Opcodes 1010 (indirect load) and 1011 (indirect store) first read the word at the PC-relative address and then use that word as the operand address. The indirect load finishes in the 6th cycle and the indirect store in the 4th.
- R6: Stores (0011, 0111, 1011) write the register named by instr[11:9], read via `rf_rb_idx`/`rf_rb_data`, with `mem_we` high. `done` is high in that write cycle, the 2nd cycle for the direct forms. Stores write no register and no flags.
- R7: Loads and the address-only operation raise `cc_we` in the same cycle as `rf_we`. In that cycle `cc_nzp` is {negative, zero, positive} (bit 2 = N, bit 1 = Z, bit 0 = P) of the value written.
- R8: `done` lasts exactly one cycle. `busy` is high from the 1st cycle after acceptance through the `done` cycle and low in the following cycle.
- R9: `start` is ignored while `busy` is high. `start` with any opcode outside the seven above is also ignored: there is no busy, no request and no done.
- R10: After reset, `busy`, `done`, `mem_req`, `mem_we`, `rf_we` and `cc_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| instr | input | 16 | Instruction word |
| pc_next | input | W | Program counter already pointing past the instruction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_ra_idx | output | 3 | Base register read index |
| rf_ra_data | input | W | Base register read data |
| rf_rb_idx | output | 3 | Store-data register read index |
| rf_rb_data | input | W | Store-data register read data |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 3 | Register write index |
| rf_wdata | output | W | Register write data |
| cc_we | output | 1 | Flag update enable |
| cc_nzp | output | 3 | New flags {N,Z,P} |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | W | Memory address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, valid the cycle after a read request |

## Verification
The bench builds the block with the default W of 16. At that width the sign bit of a 9-bit or 6-bit offset lands in the top bit of a full machine word, and an address computed at 0x0000 minus one wraps to 0xFFFF. Negative offsets on both addressing forms, a negative loaded value, a zero loaded value, and a two-step pointer chase whose pointer points far from its own location are all exercised with exact cycle counts and exact access addresses.

// File: rtl/ldst_seq.sv
module ldst_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [15:0]  instr,
  input  logic [W-1:0] pc_next,
  output logic         busy,
  output logic         done,
  output logic [2:0]   rf_ra_idx,
  input  logic [W-1:0] rf_ra_data,
  output logic [2:0]   rf_rb_idx,
  input  logic [W-1:0] rf_rb_data,
  output logic         rf_we,
  output logic [2:0]   rf_widx,
  output logic [W-1:0] rf_wdata,
  output logic         cc_we,
  output logic [2:0]   cc_nzp,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata
);
  localparam logic [3:0] OP_LD  = 4'b0010;
  localparam logic [3:0] OP_ST  = 4'b0011;
  localparam logic [3:0] OP_LDR = 4'b0110;
  localparam logic [3:0] OP_STR = 4'b0111;
  localparam logic [3:0] OP_LDI = 4'b1010;
  localparam logic [3:0] OP_STI = 4'b1011;
  localparam logic [3:0] OP_LEA = 4'b1110;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_IND, S_INDW, S_MEM, S_LDW, S_WB} st_t;

  st_t         st;
  logic [15:0] ir;
  logic [W-1:0] pcn, mar, mdr;

  logic [3:0] op, start_op;
  logic       is_lea, is_ind, is_st, is_base, start_ok;
  logic [W-1:0] off9, off6, ea;

  assign op       = ir[15:12];
  assign start_op = instr[15:12];
  assign start_ok = start_op inside {OP_LD, OP_ST, OP_LDR, OP_STR, OP_LDI, OP_STI, OP_LEA};
  assign is_lea   = op == OP_LEA;
  assign is_ind   = op == OP_LDI || op == OP_STI;
  assign is_st    = op == OP_ST || op == OP_STR || op == OP_STI;
  assign is_base  = op == OP_LDR || op == OP_STR;

  assign off9 = {{(W-9){ir[8]}}, ir[8:0]};
  assign off6 = {{(W-6){ir[5]}}, ir[5:0]};
  assign ea   = is_base ? rf_ra_data + off6 : pcn + off9;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      ir  <= '0;
      pcn <= '0;
      mar <= '0;
      mdr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && start_ok) begin
          ir  <= instr;
          pcn <= pc_next;
          st  <= S_ADDR;
        end
        S_ADDR: begin
          mar <= ea;
          if (is_lea) begin
            mdr <= ea;
            st  <= S_WB;
          end else begin
            if (is_st) mdr <= rf_rb_data;
            st <= is_ind ? S_IND : S_MEM;
          end
        end
        S_IND:  st <= S_INDW;
        S_INDW: begin
          mar <= mem_rdata;
          st  <= S_MEM;
        end
        S_MEM:  st <= is_st ? S_IDLE : S_LDW;
        S_LDW: begin
          mdr <= mem_rdata;
          st  <= S_WB;
        end
        S_WB:    st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rf_ra_idx = ir[8:6];
  assign rf_rb_idx = ir[11:9];
  assign mem_req   = st == S_IND || st == S_MEM;
  assign mem_we    = st == S_MEM && is_st;
  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign rf_we     = st == S_WB;
  assign rf_widx   = ir[11:9];
  assign rf_wdata  = mdr;
  assign cc_we     = rf_we;
  assign cc_nzp    = {mdr[W-1], mdr == '0, !mdr[W-1] && mdr != '0};
  assign done      = rf_we || mem_we;
  assign busy      = st != S_IDLE;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_ind_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MEM && $past(st) == S_INDW) |-> mem_addr == $past(mem_rdata));
  p_store_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!cc_we && !rf_we));
  p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cc_we |-> ($countones(cc_nzp) == 1 && cc_nzp[2] == rf_wdata[W-1] && rf_we));
  p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !start_ok) |=> !busy);
endmodule

// File: tb/ldst_seq_tb.sv
`timescale 1ns/1ps
module ldst_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_next = '0;
  logic busy, done, rf_we, cc_we, mem_req, mem_we;
  logic [2:0] rf_ra_idx, rf_rb_idx, rf_widx, cc_nzp;
  logic [15:0] rf_ra_data, rf_rb_data, rf_wdata, mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  ldst_seq #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_next(pc_next),
    .busy(busy), .done(done), .rf_ra_idx(rf_ra_idx), .rf_ra_data(rf_ra_data),
    .rf_rb_idx(rf_rb_idx), .rf_rb_data(rf_rb_data), .rf_we(rf_we), .rf_widx(rf_widx),
    .rf_wdata(rf_wdata), .cc_we(cc_we), .cc_nzp(cc_nzp), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [15:0] rf [8];
  logic [15:0] mem [1024];
  logic [15:0] rq;
  int n_chk = 0, n_err = 0;
  int n_req, n_rfw, n_ccw;
  logic [15:0] ra [4];
  logic        rw [4];
  logic [2:0]  last_cc;

  assign rf_ra_data = rf[rf_ra_idx];
  assign rf_rb_data = rf[rf_rb_idx];
  assign mem_rdata  = rq;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else rq <= mem[mem_addr[9:0]];
      if (n_req < 4) begin
        ra[n_req] = mem_addr;
        rw[n_req] = mem_we;
      end
      n_req = n_req + 1;
    end
    if (rf_we) begin
      rf[rf_widx] <= rf_wdata;
      n_rfw = n_rfw + 1;
    end
    if (cc_we) begin
      last_cc = cc_nzp;
      n_ccw = n_ccw + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int lat;
  task automatic run_op(input logic [15:0] i, input logic [15:0] pc, input bit poke_busy);
    @(negedge clk);
    n_req = 0; n_rfw = 0; n_ccw = 0; last_cc = 3'b000;
    instr = i; pc_next = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      lat++;
      if (lat == 1) chk(busy === 1'b1, "R8 busy after accept", busy, 1);
      if (poke_busy && lat == 2) begin
        instr = 16'hE3FF; pc_next = 16'h0000; start = 1'b1;
      end
      if (poke_busy && lat == 3) start = 1'b0;
      if (done === 1'b1) break;
      @(negedge clk);
    end
    chk(done === 1'b1, "R8 done seen", done, 1);
    chk(busy === 1'b1, "R8 busy in done cycle", busy, 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R8 done one cycle", {done, busy}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !mem_req && !mem_we && !rf_we && !cc_we, "R10 reset outputs",
        {busy, done, mem_req, mem_we, rf_we, cc_we}, 0);
  endtask

  task automatic t_lea;
    run_op(16'hE3FF, 16'h3001, 0);
    chk(lat == 2, "R3 lea latency", lat, 2);
    chk(n_req == 0, "R3 lea no memory", n_req, 0);
    chk(rf[1] == 16'h3000, "R1 R3 lea value", rf[1], 16'h3000);
    chk(last_cc == 3'b001, "R7 lea flags P", last_cc, 3'b001);
    run_op(16'hE3FF, 16'h0000, 0);
    chk(rf[1] == 16'hFFFF, "R1 wraparound", rf[1], 16'hFFFF);
    chk(last_cc == 3'b100, "R7 lea flags N", last_cc, 3'b100);
  endtask

  task automatic t_ld;
    mem[10'h015] = 16'h8000;
    run_op(16'h2405, 16'h3010, 0);
    chk(lat == 4, "R4 ld latency", lat, 4);
    chk(n_req == 1 && ra[0] == 16'h3015 && !rw[0], "R1 ld address", ra[0], 16'h3015);
    chk(rf[2] == 16'h8000, "R4 ld value", rf[2], 16'h8000);
    chk(last_cc == 3'b100 && n_ccw == 1, "R7 ld flags N", last_cc, 3'b100);
    mem[10'h01D] = 16'h0000;
    rf[3] = 16'h5555;
    run_op(16'h27FD, 16'h3020, 0);
    chk(ra[0] == 16'h301D, "R1 negative offset", ra[0], 16'h301D);
    chk(rf[3] == 16'h0000, "R4 ld zero", rf[3], 0);
    chk(last_cc == 3'b010, "R7 ld flags Z", last_cc, 3'b010);
  endtask

  task automatic t_ldr;
    rf[5] = 16'h3100;
    mem[10'h0FE] = 16'h1234;
    run_op(16'h697E, 16'h0000, 0);
    chk(lat == 4, "R4 ldr latency", lat, 4);
    chk(ra[0] == 16'h30FE, "R2 base minus offset", ra[0], 16'h30FE);
    chk(rf[4] == 16'h1234, "R2 ldr value", rf[4], 16'h1234);
  endtask

  task automatic t_ldi;
    mem[10'h042] = 16'h3200;
    mem[10'h200] = 16'h0007;
    run_op(16'hAC02, 16'h3040, 0);
    chk(lat == 6, "R5 ldi latency", lat, 6);
    chk(n_req == 2, "R5 ldi two reads", n_req, 2);
    chk(ra[0] == 16'h3042 && ra[1] == 16'h3200 && !rw[0] && !rw[1], "R5 ldi addresses",
        {ra[0], ra[1]}, {16'h3042, 16'h3200});
    chk(rf[6] == 16'h0007 && last_cc == 3'b001, "R5 R7 ldi value", rf[6], 16'h0007);
  endtask

  task automatic t_st;
    rf[3] = 16'hBEEF;
    run_op(16'h3610, 16'h3050, 0);
    chk(lat == 2, "R6 st latency", lat, 2);
    chk(n_req == 1 && rw[0] && ra[0] == 16'h3060, "R6 st address", ra[0], 16'h3060);
    chk(mem[10'h060] == 16'hBEEF, "R6 st data", mem[10'h060], 16'hBEEF);
    chk(n_rfw == 0 && n_ccw == 0, "R6 st no reg or flag write", {n_rfw, n_ccw}, 0);
    rf[7] = 16'hA5A5;
    run_op(16'h7F5F, 16'h0000, 0);
    chk(ra[0] == 16'h311F && mem[10'h11F] == 16'hA5A5, "R2 R6 str", mem[10'h11F], 16'hA5A5);
  endtask

  task automatic t_sti;
    rf[0] = 16'h0042;
    mem[10'h06F] = 16'h3300;
    run_op(16'hB1FF, 16'h3070, 0);
    chk(lat == 4, "R5 sti latency", lat, 4);
    chk(n_req == 2 && !rw[0] && rw[1], "R5 sti read then write", {rw[0], rw[1]}, 2'b01);
    chk(ra[0] == 16'h306F && ra[1] == 16'h3300, "R5 sti addresses", {ra[0], ra[1]},
        {16'h306F, 16'h3300});
    chk(mem[10'h300] == 16'h0042 && n_ccw == 0, "R5 R6 sti data", mem[10'h300], 16'h0042);
  endtask

  task automatic t_ignore;
    rf[1] = 16'h7777;
    mem[10'h042] = 16'h3200;
    mem[10'h200] = 16'h0009;
    run_op(16'hAC02, 16'h3040, 1);
    chk(lat == 6, "R9 busy start latency", lat, 6);
    chk(rf[1] == 16'h7777, "R9 busy start ignored", rf[1], 16'h7777);
    chk(rf[6] == 16'h0009, "R9 first op intact", rf[6], 16'h0009);
    @(negedge clk);
    chk(busy === 1'b0, "R9 no late start", busy, 0);
    n_req = 0; n_rfw = 0;
    instr = 16'h1000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(!busy && !done, "R9 bad opcode idle", {busy, done}, 0);
      @(negedge clk);
    end
    chk(n_req == 0 && n_rfw == 0, "R9 bad opcode no access", {n_req, n_rfw}, 0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) rf[k] = '0;
    for (int k = 0; k < 1024; k++) mem[k] = '0;
    rq = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lea();
    t_ld();
    t_ldr();
    t_ldi();
    t_st();
    t_sti();
    t_ignore();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule